// File: doc/BRIEF.md
# Fractional-Divisor UART Receiver

This block receives serial characters using only a slow timing tick, such as a 32,768 Hz real-time clock enable, as its sense of time. At that tick rate a 9,600 baud line needs about 3.41 ticks per bit. No whole number of ticks fits that. A constant divide-by-3 runs near 10,922 baud and a constant divide-by-4 near 8,192 baud, and both drift far enough across a frame to sample the wrong bit by the third data bit. The receiver therefore sets the length of each bit period separately. It uses the configured integer divisor or that divisor plus one, chosen by the carry out of a fractional accumulator. The mean period then matches the ideal ratio and the error stays bounded instead of growing.

A character is a low start bit, eight data bits sent least significant bit first, an even parity bit and a high stop bit. The line passes through a synchronizer. A high-to-low change seen on a tick opens a frame. Each bit is then read once near its middle. After the stop sample the byte and two error flags are presented, and a one-cycle strobe marks them. The scheme is meant for 9,600 baud and slower rates on a 32 kHz tick.

Top module: `fracdiv_uart_rx`

## Requirements
- R1: After reset `rx_valid`, `parity_err` and `frame_err` are 0, `rx_data` is 0, and no frame is in progress.
- R2: A frame opens only on a tick where the synchronized line is low and was high on the previous tick. If the start bit reads high at its sample point, the frame is dropped without a `rx_valid` pulse, and the receiver then accepts the next frame.
- R3: The start bit is sampled floor((div_int*256+div_frac)/512) ticks after the opening tick, or 1 tick if that value is 0. Each later bit is sampled one bit period after the previous one.
- R4: Each bit period lasts `div_int` ticks, or `div_int`+1 ticks when adding `div_frac` to an 8-bit accumulator carries. The accumulator is cleared when each frame opens. With `div_frac`=0 and a 9,600 baud line on the 32,768 Hz tick, the byte 0x0F is not received intact.
- R5: With `div_int`=3, `div_frac`=106 and 9,600 baud frames on a 32,768 Hz tick, every byte value is received intact with no error flag.
- R6: With `div_frac`=0, frames whose bits last exactly `div_int` ticks are received intact, for `div_int` of 3 and 4.
- R7: The first data bit after the start bit goes to `rx_data[0]` and the eighth goes to `rx_data[7]`.
- R8: The parity bit follows the eighth data bit. `parity_err` is 1 when the count of ones over the data and parity bits is odd. The byte is delivered either way.
- R9: `frame_err` is 1 when the line reads low at the stop bit sample point, and 0 when it reads high.
- R10: `rx_valid` is high for exactly one clock cycle per completed frame. `rx_data`, `parity_err` and `frame_err` hold their values until the next completed frame.
- R11: A frame that starts one bit period after the previous stop bit is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_32k | input | 1 | One-cycle timing enable at the slow tick rate |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| div_int | input | 4 | Integer part of the ticks-per-bit ratio, 2 or more |
| div_frac | input | 8 | Fractional part of the ticks-per-bit ratio in 1/256 units |
| rx_data | output | 8 | Last received byte |
| parity_err | output | 1 | Even-parity mismatch on the last frame |
| frame_err | output | 1 | Stop bit read low on the last frame |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |

## Verification
The bench builds the receiver with its default widths: a 4-bit integer divisor, an 8-bit fraction, 8 data bits and a two-stage synchronizer. It drives a tick on every 16th clock. That spacing lets it place line transitions at the exact fractional positions of a 9,600 baud transmitter relative to the 32,768 Hz tick. With this setup the bench can show that the dithered divisor recovers whole frames and that a fixed divide-by-3 misreads the same frames. The integer-only settings are run against line rates that match them exactly. The bench also covers glitches, parity and stop errors, and back-to-back frames.

// File: rtl/fdrx_pkg.sv
package fdrx_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/fdrx_sync.sv
module fdrx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fdrx_bit_timer.sv
module fdrx_bit_timer #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic              run_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              sample_o
);
  localparam int CNT_W  = INT_W + 1;
  localparam int FULL_W = INT_W + FRAC_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FULL_W-1:0] half_full;
  logic [CNT_W-1:0]  first_wait;
  logic [CNT_W-1:0]  reload;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;

  always_comb begin
    half_full  = {div_int_i, div_frac_i} >> (FRAC_W + 1);
    first_wait = (half_full[CNT_W-1:0] == '0) ? CNT_W'(1) : half_full[CNT_W-1:0];
    acc_sum    = {1'b0, acc_q} + {1'b0, div_frac_i};
    carry      = acc_sum[FRAC_W];
    reload     = {1'b0, div_int_i} + {{(CNT_W-1){1'b0}}, carry};
    sample_o   = run_i && tick_i && (cnt_q <= CNT_W'(1));

    cnt_d = cnt_q;
    acc_d = acc_q;
    if (arm_i) begin
      cnt_d = first_wait;
      acc_d = '0;
    end else if (run_i && tick_i) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = reload;
        acc_d = acc_sum[FRAC_W-1:0];
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R4: after each sample the next period is the integer divisor or one more
  assert_reload_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !arm_i && $stable(div_int_i)) |=>
      (cnt_q == {1'b0, $past(div_int_i)} || cnt_q == ({1'b0, $past(div_int_i)} + CNT_W'(1))));

  // R3: a newly armed frame never waits zero ticks
  assert_first_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (cnt_q != '0));
endmodule

// File: rtl/fdrx_frame.sv
module fdrx_frame
  import fdrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              sample_i,
  output logic              arm_o,
  output logic              run_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              valid_o
);
  localparam int IDX_W   = $clog2(DATA_W + 3);
  localparam int PAR_IDX = DATA_W + 1;

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              prev_q, prev_d;
  logic [DATA_W-1:0] data_d;
  logic              perr_d, ferr_d, valid_d;

  always_comb begin
    arm_o   = (state_q == RX_IDLE) && tick_i && prev_q && !line_i;
    run_o   = (state_q == RX_BUSY);
    state_d = state_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    prev_d  = tick_i ? line_i : prev_q;
    data_d  = data_o;
    perr_d  = perr_o;
    ferr_d  = ferr_o;
    valid_d = 1'b0;

    if (arm_o) begin
      state_d = RX_BUSY;
      idx_d   = '0;
    end else if (sample_i) begin
      if (idx_q == '0) begin
        if (line_i) state_d = RX_IDLE;
        else        idx_d   = IDX_W'(1);
      end else if (idx_q <= IDX_W'(DATA_W)) begin
        sh_d  = {line_i, sh_q[DATA_W-1:1]};
        idx_d = idx_q + IDX_W'(1);
      end else if (idx_q == IDX_W'(PAR_IDX)) begin
        pbit_d = line_i;
        idx_d  = idx_q + IDX_W'(1);
      end else begin
        data_d  = sh_q;
        perr_d  = ^{sh_q, pbit_q};
        ferr_d  = !line_i;
        valid_d = 1'b1;
        state_d = RX_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      prev_q  <= 1'b1;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      prev_q  <= prev_d;
      data_o  <= data_d;
      perr_o  <= perr_d;
      ferr_o  <= ferr_d;
      valid_o <= valid_d;
    end
  end

  // R10: completion strobe lasts a single cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R10: completion only follows a slow-tick cycle
  assert_valid_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick_i));

  // R10: results hold between completions
  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable({data_o, perr_o, ferr_o}));

  // R2: a frame opens only while the line is low
  assert_open_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> !$past(line_i));
endmodule

// File: rtl/fracdiv_uart_rx.sv
module fracdiv_uart_rx #(
  parameter int DIV_INT_W   = 4,
  parameter int DIV_FRAC_W  = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_32k,
  input  logic                  rx_serial,
  input  logic [DIV_INT_W-1:0]  div_int,
  input  logic [DIV_FRAC_W-1:0] div_frac,
  output logic [DATA_W-1:0]     rx_data,
  output logic                  parity_err,
  output logic                  frame_err,
  output logic                  rx_valid
);
  logic rst_n_s;
  logic line_s;
  logic arm, run, sample;

  fdrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  fdrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(rx_serial), .q_o(line_s)
  );

  fdrx_bit_timer #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick_32k), .arm_i(arm), .run_i(run),
    .div_int_i(div_int), .div_frac_i(div_frac), .sample_o(sample)
  );

  fdrx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick_32k), .line_i(line_s),
    .sample_i(sample), .arm_o(arm), .run_o(run), .data_o(rx_data),
    .perr_o(parity_err), .ferr_o(frame_err), .valid_o(rx_valid)
  );
endmodule

// File: tb/fracdiv_uart_rx_test.sv
module fracdiv_uart_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 16;
  localparam longint N9600  = 64'd524288; // clocks per bit * 9600 = 16*32768
  localparam longint D9600  = 64'd9600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [3:0] dint = 4'd3;
  logic [7:0] dfrac = 8'd106;
  logic [7:0] rx_data;
  logic       parity_err, frame_err, rx_valid;

  int n_chk = 0;
  int n_bad = 0;
  int tdiv = 0;
  int ncap = 0;
  logic [7:0] cap_data [2];
  logic       cap_perr [2];
  logic       cap_ferr [2];

  fracdiv_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .rx_serial(rx),
    .div_int(dint), .div_frac(dfrac), .rx_data(rx_data),
    .parity_err(parity_err), .frame_err(frame_err), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == TICK_DIV-1) begin tdiv <= 0; tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick <= 1'b0; end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (ncap < 2) begin
        cap_data[ncap] = rx_data;
        cap_perr[ncap] = parity_err;
        cap_ferr[ncap] = frame_err;
      end
      ncap = ncap + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit pflip, input bit stopv);
    mk_frame = {stopv, (^b) ^ pflip, b, 1'b0};
  endfunction

  task automatic send_bits(input logic [31:0] bits, input int n, input longint num, input longint den);
    longint total;
    do @(negedge clk); while (!tick);
    repeat (5) @(negedge clk);
    total = (longint'(n) * num) / den;
    for (longint c = 0; c < total; c++) begin
      longint j;
      j = (c * den) / num;
      rx = (j < n) ? bits[j] : 1'b1;
      @(negedge clk);
    end
    rx = 1'b1;
    repeat (6 * TICK_DIV) @(negedge clk);
  endtask

  task automatic rx_one(input logic [7:0] b, input bit pflip, input bit stopv,
                        input longint num, input longint den, input string req,
                        input bit exp_perr, input bit exp_ferr);
    ncap = 0;
    send_bits({21'h1fffff, mk_frame(b, pflip, stopv)}, 11, num, den);
    check(ncap == 1, req, "valid pulse count", ncap, 1);
    check(cap_data[0] == b, req, "data", cap_data[0], b);
    check(cap_perr[0] == exp_perr, req, "parity_err", cap_perr[0], exp_perr);
    check(cap_ferr[0] == exp_ferr, req, "frame_err", cap_ferr[0], exp_ferr);
  endtask

  task automatic t_reset;
    check(rx_valid == 0, "R1", "rx_valid", rx_valid, 0);
    check(rx_data == 0, "R1", "rx_data", rx_data, 0);
    check(parity_err == 0 && frame_err == 0, "R1", "flags", {parity_err, frame_err}, 0);
  endtask

  task automatic t_nominal;
    logic [7:0] pats [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h0F, 8'hC6};
    dint = 4'd3; dfrac = 8'd106;
    foreach (pats[i]) rx_one(pats[i], 0, 1, N9600, D9600, "R5_R3", 0, 0);
  endtask

  task automatic t_lsb_first;
    rx_one(8'h01, 0, 1, N9600, D9600, "R7", 0, 0);
    rx_one(8'h80, 0, 1, N9600, D9600, "R7", 0, 0);
  endtask

  task automatic t_parity;
    rx_one(8'h3C, 1, 1, N9600, D9600, "R8", 1, 0);
    rx_one(8'h07, 1, 1, N9600, D9600, "R8", 1, 0);
  endtask

  task automatic t_framing;
    rx_one(8'h5A, 0, 0, N9600, D9600, "R9", 0, 1);
  endtask

  task automatic t_integer_only;
    dint = 4'd3; dfrac = 8'd0;
    rx_one(8'hA5, 0, 1, 64'd48, 64'd1, "R6", 0, 0);
    dint = 4'd4; dfrac = 8'd0;
    rx_one(8'h5A, 0, 1, 64'd64, 64'd1, "R6", 0, 0);
  endtask

  task automatic t_fixed_fails;
    dint = 4'd3; dfrac = 8'd0;
    ncap = 0;
    send_bits({21'h1fffff, mk_frame(8'h0F, 0, 1)}, 11, N9600, D9600);
    check(ncap == 1 && cap_data[0] != 8'h0F, "R4", "fixed divisor must misread", cap_data[0], 8'h0F);
    dint = 4'd3; dfrac = 8'd106;
  endtask

  task automatic t_glitch;
    ncap = 0;
    do @(negedge clk); while (!tick);
    repeat (5) @(negedge clk);
    rx = 1'b0;
    repeat (14) @(negedge clk);
    rx = 1'b1;
    repeat (8 * TICK_DIV) @(negedge clk);
    check(ncap == 0, "R2", "no valid after glitch", ncap, 0);
    rx_one(8'h96, 0, 1, N9600, D9600, "R2", 0, 0);
  endtask

  task automatic t_hold;
    rx_one(8'h3C, 1, 1, N9600, D9600, "R10", 1, 0);
    repeat (300) @(negedge clk);
    check(rx_data == 8'h3C && parity_err && !frame_err, "R10", "held outputs",
          {parity_err, frame_err, rx_data}, {2'b10, 8'h3C});
    check(rx_valid == 0, "R10", "valid low between frames", rx_valid, 0);
  endtask

  task automatic t_back_to_back;
    ncap = 0;
    send_bits({9'h1ff, 1'b1, mk_frame(8'hE1, 0, 1), mk_frame(8'h2B, 0, 1)}, 23, N9600, D9600);
    check(ncap == 2, "R11", "frame count", ncap, 2);
    check(cap_data[0] == 8'h2B, "R11", "first byte", cap_data[0], 8'h2B);
    check(cap_data[1] == 8'hE1, "R11", "second byte", cap_data[1], 8'hE1);
    check(!cap_perr[1] && !cap_ferr[1], "R11", "second flags", {cap_perr[1], cap_ferr[1]}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_nominal();
    t_lsb_first();
    t_parity();
    t_framing();
    t_integer_only();
    t_fixed_fails();
    t_glitch();
    t_hold();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule